// File: doc/BRIEF.md
# MII Collision and Carrier-Sense Generator

This block produces the two line-status outputs a MAC watches on a nibble-wide media-independent interface: the collision flag (COL) and the carrier flag (CRS). It works from activity indications supplied by the rest of the PHY. These are a transmit-in-progress level, a receive-in-progress level and, for the 100 Mb/s path, a signal-detect level with the raw received bit stream. From these it applies the duplex, speed and heartbeat rules. All state advances only on cycles where the bit-rate clock enable is high, so one enable pulse is one bit time at the selected speed.

In half duplex, simultaneous transmit and receive is a collision. At 10 Mb/s, a collision that appears while the block is already transmitting is held back for seven bit times, so short noise bursts are not reported. A collision that appears while a receive is already under way is reported at once. With heartbeat enabled at 10 Mb/s, every end of transmission is followed by a gap and then a short signal-quality pulse on COL. At 100 Mb/s, receive carrier is recognised from the bit stream itself rather than from the receive level.

Top module: `mii_line_status`

## Requirements
- R1: In half duplex, COL is asserted when transmit and receive activity are both present. In full duplex, COL is asserted only by the heartbeat pulse.
- R2: At 10 Mb/s, if transmit was active and receive was not at the previous tick, a new collision raises COL only at the tick that samples its seventh consecutive collision bit. COL is low after the first six such ticks.
- R3: A collision that starts while receive was already active at the previous tick, or that starts with both activities at the same tick, or any collision at 100 Mb/s, raises COL at the first collision tick.
- R4: COL stays high while the collision lasts and falls at the first tick without it. The seven-bit filter count restarts from zero whenever transmit or receive activity drops.
- R5: With heartbeat enabled at 10 Mb/s, when transmit activity is first sampled low at tick F, COL is high after ticks F+10 through F+19 and low after F+20. There is no pulse at 100 Mb/s or with heartbeat disabled.
- R6: A transmit that restarts before or during the heartbeat pulse cancels the pulse from that tick on.
- R7: In half duplex, CRS is asserted for transmit or receive activity. In full duplex, it is asserted for receive activity only.
- R8: At 100 Mb/s, with signal-detect high, receive carrier begins at the tick that samples a zero bit that follows an earlier zero with at least one one bit in between. Adjacent zeros alone do not start carrier, and the receive-active input does not start it.
- R9: At 100 Mb/s, carrier ends at the tick where receive activity is first sampled low after being high, or at any tick with signal-detect low. At 10 Mb/s, receive activity is the receive-active input itself.
- R10: After reset, COL and CRS are low. Both outputs and all state change only at ticks with the bit-rate enable high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | Bit-time clock enable |
| full_dup | input | 1 | 1 = full duplex, 0 = half duplex |
| spd_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| hb_en | input | 1 | Heartbeat (SQE) enable |
| tx_act | input | 1 | Transmit activity level |
| rx_act | input | 1 | Receive activity level (packet in progress) |
| sig_det | input | 1 | 100 Mb/s signal-detect level |
| rx_bit | input | 1 | Received bit stream for carrier start detection |
| col | output | 1 | Collision indication |
| crs | output | 1 | Carrier-sense indication |

## Verification
A collision filter counter that failed to clear shows at the ports as COL rising early on the next collision, within the first six ticks of that collision. A heartbeat phase counter that was off by one moves the pulse edge by one tick at F+10 or F+20. A stuck 100 Mb/s carrier flag leaves CRS high one tick after the end of the packet or after signal-detect drops. Every such error therefore shows within at most twenty ticks of the stimulus, and each scenario samples the outputs after every tick across that window.

// File: rtl/mii_ls_pkg.sv
package mii_ls_pkg;
  typedef enum logic [1:0] {HB_IDLE, HB_WAIT, HB_PULSE} hb_phase_e;
  typedef enum logic [1:0] {DT_SEEK, DT_ZERO, DT_GAP} det_phase_e;
endpackage

// File: rtl/mii_ls_carrier.sv
module mii_ls_carrier
  import mii_ls_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic spd_100,
  input  logic sig_det,
  input  logic rx_bit,
  input  logic rx_act,
  output logic rx_on_d
);
  det_phase_e ph_q, ph_d;
  logic car_q, car_d;
  logic rxa_q, rxa_d;

  always_comb begin
    ph_d  = ph_q;
    car_d = car_q;
    rxa_d = rxa_q;
    if (bit_tick) begin
      rxa_d = rx_act;
      if (!spd_100 || !sig_det) begin
        ph_d  = DT_SEEK;
        car_d = 1'b0;
      end else if (car_q) begin
        ph_d = DT_SEEK;
        if (rxa_q && !rx_act) car_d = 1'b0;
      end else begin
        unique case (ph_q)
          DT_SEEK: if (!rx_bit) ph_d = DT_ZERO;
          DT_ZERO: if (rx_bit)  ph_d = DT_GAP;
          DT_GAP:  if (!rx_bit) begin
                     ph_d  = DT_SEEK;
                     car_d = 1'b1;
                   end
          default: ph_d = DT_SEEK;
        endcase
      end
    end
  end

  assign rx_on_d = spd_100 ? car_d : rx_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= DT_SEEK;
      car_q <= 1'b0;
      rxa_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      car_q <= car_d;
      rxa_q <= rxa_d;
    end
  end

  // R8: carrier only ever starts on a tick with signal-detect at 100 Mb/s
  p_car_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(car_q) |-> $past(bit_tick && sig_det && spd_100));
endmodule

// File: rtl/mii_ls_colfilt.sv
module mii_ls_colfilt #(
  parameter int FILT_BITS = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic full_dup,
  input  logic spd_100,
  input  logic tx_act,
  input  logic rx_on,
  output logic hit
);
  localparam int CW = $clog2(FILT_BITS + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic filt_q, filt_d;
  logic tx_q, tx_d, rx_q, rx_d;
  logic coll, onset;

  assign coll  = !full_dup && tx_act && rx_on;
  assign onset = coll && !(tx_q && rx_q);

  always_comb begin
    cnt_d  = cnt_q;
    filt_d = filt_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    if (bit_tick) begin
      tx_d = tx_act;
      rx_d = rx_on;
      if (!coll) begin
        cnt_d  = '0;
        filt_d = 1'b0;
      end else begin
        if (onset) filt_d = !spd_100 && tx_q && !rx_q;
        if (cnt_q != CW'(FILT_BITS)) cnt_d = cnt_q + 1'b1;
      end
    end
  end

  assign hit = bit_tick && coll && (!filt_d || cnt_d == CW'(FILT_BITS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
      tx_q   <= 1'b0;
      rx_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      filt_q <= filt_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
    end
  end

  // R2: the filter count never runs past its limit
  p_cnt_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(FILT_BITS));
  // R4: a tick without transmit activity leaves the count cleared
  p_cnt_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && !tx_act) |=> (cnt_q == '0));
endmodule

// File: rtl/mii_ls_sqe.sv
module mii_ls_sqe
  import mii_ls_pkg::*;
#(
  parameter int GAP_BITS   = 10,
  parameter int PULSE_BITS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic spd_100,
  input  logic hb_en,
  input  logic tx_act,
  output logic pulse_d,
  output logic pulse_q
);
  localparam int MAXB = (GAP_BITS > PULSE_BITS) ? GAP_BITS : PULSE_BITS;
  localparam int CW   = (MAXB > 1) ? $clog2(MAXB) : 1;

  hb_phase_e ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic tx_q, tx_d;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    tx_d  = tx_q;
    if (bit_tick) begin
      tx_d = tx_act;
      if (!hb_en || spd_100 || tx_act) begin
        ph_d  = HB_IDLE;
        cnt_d = '0;
      end else if (tx_q) begin
        ph_d  = HB_WAIT;
        cnt_d = '0;
      end else begin
        unique case (ph_q)
          HB_WAIT: if (cnt_q == CW'(GAP_BITS - 1)) begin
                     ph_d  = HB_PULSE;
                     cnt_d = '0;
                   end else cnt_d = cnt_q + 1'b1;
          HB_PULSE: if (cnt_q == CW'(PULSE_BITS - 1)) begin
                     ph_d  = HB_IDLE;
                     cnt_d = '0;
                   end else cnt_d = cnt_q + 1'b1;
          default: ph_d = HB_IDLE;
        endcase
      end
    end
  end

  assign pulse_d = (ph_d == HB_PULSE);
  assign pulse_q = (ph_q == HB_PULSE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= HB_IDLE;
      cnt_q <= '0;
      tx_q  <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      tx_q  <= tx_d;
    end
  end

  // R6: the pulse never begins on a tick with transmit active
  p_pulse_no_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_q) |-> $past(!tx_act && hb_en && !spd_100));
  // R5: phase counter stays inside its window
  p_phase_cnt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(MAXB));
endmodule

// File: rtl/mii_line_status.sv
module mii_line_status #(
  parameter int FILT_BITS  = 7,
  parameter int GAP_BITS   = 10,
  parameter int PULSE_BITS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic full_dup,
  input  logic spd_100,
  input  logic hb_en,
  input  logic tx_act,
  input  logic rx_act,
  input  logic sig_det,
  input  logic rx_bit,
  output logic col,
  output logic crs
);
  logic rx_on_d, hit, pulse_d, pulse_q;
  logic col_q, col_d, crs_q, crs_d;

  mii_ls_carrier u_car (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .spd_100(spd_100),
    .sig_det(sig_det), .rx_bit(rx_bit), .rx_act(rx_act), .rx_on_d(rx_on_d)
  );

  mii_ls_colfilt #(.FILT_BITS(FILT_BITS)) u_filt (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .full_dup(full_dup),
    .spd_100(spd_100), .tx_act(tx_act), .rx_on(rx_on_d), .hit(hit)
  );

  mii_ls_sqe #(.GAP_BITS(GAP_BITS), .PULSE_BITS(PULSE_BITS)) u_sqe (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .spd_100(spd_100),
    .hb_en(hb_en), .tx_act(tx_act), .pulse_d(pulse_d), .pulse_q(pulse_q)
  );

  always_comb begin
    col_d = col_q;
    crs_d = crs_q;
    if (bit_tick) begin
      col_d = hit || pulse_d;
      crs_d = rx_on_d || (!full_dup && tx_act);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= 1'b0;
      crs_q <= 1'b0;
    end else begin
      col_q <= col_d;
      crs_q <= crs_d;
    end
  end

  assign col = col_q;
  assign crs = crs_q;

  // R1: in full duplex only the heartbeat can drive COL
  p_fd_col_sqe_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && full_dup && !pulse_d) |=> !col);
  // R7: full duplex carrier follows receive only
  p_fd_crs_rx_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && full_dup && !rx_on_d) |=> !crs);
  // R4: a reported collision always comes with carrier
  p_col_has_crs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (col && !pulse_q) |-> crs);
  // R10: outputs hold between ticks
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> ($stable(col) && $stable(crs)));
endmodule

// File: tb/mii_line_status_tb.sv
module mii_line_status_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic clk, rst_n, bit_tick;
  logic full_dup, spd_100, hb_en, tx_act, rx_act, sig_det, rx_bit;
  logic col, crs;
  int n_chk, n_err;
  bit done;

  mii_line_status dut_i (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .full_dup(full_dup),
    .spd_100(spd_100), .hb_en(hb_en), .tx_act(tx_act), .rx_act(rx_act),
    .sig_det(sig_det), .rx_bit(rx_bit), .col(col), .crs(crs)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk) bit_tick = 1'b1;
    @(negedge clk) bit_tick = 1'b0;
  endtask

  task automatic quiet();
    tx_act = 0; rx_act = 0; sig_det = 0; rx_bit = 1;
    repeat (3) step();
  endtask

  task automatic t_reset();
    chk(col, 1'b0, "R10", "col after reset");
    chk(crs, 1'b0, "R10", "crs after reset");
  endtask

  task automatic t_crs_modes();
    full_dup = 0; spd_100 = 0; hb_en = 0;
    tx_act = 1; step(); chk(crs, 1'b1, "R7", "hd crs on tx");
    tx_act = 0; rx_act = 1; step(); chk(crs, 1'b1, "R7", "hd crs on rx");
    full_dup = 1; rx_act = 0; tx_act = 1; step(); chk(crs, 1'b0, "R7", "fd crs ignores tx");
    rx_act = 1; tx_act = 0; step(); chk(crs, 1'b1, "R7", "fd crs on rx");
    quiet();
  endtask

  task automatic t_fd_col();
    full_dup = 1; spd_100 = 0; hb_en = 0;
    tx_act = 1; rx_act = 1;
    for (int i = 0; i < 10; i++) begin
      step(); chk(col, 1'b0, "R1", "fd no collision");
    end
    full_dup = 0; step(); chk(col, 1'b1, "R1", "hd collision reported");
    quiet();
  endtask

  task automatic t_filter();
    full_dup = 0; spd_100 = 0; hb_en = 0;
    tx_act = 1; step(); chk(col, 1'b0, "R2", "tx alone");
    rx_act = 1;
    for (int i = 1; i <= 7; i++) begin
      step(); chk(col, (i == 7), "R2", $sformatf("filtered tick %0d", i));
    end
    repeat (3) begin
      step(); chk(col, 1'b1, "R4", "col held");
    end
    rx_act = 0; step(); chk(col, 1'b0, "R4", "col drops at end");
    rx_act = 1; repeat (4) step();
    rx_act = 0; step(); chk(col, 1'b0, "R4", "short burst");
    rx_act = 1;
    for (int i = 1; i <= 7; i++) begin
      step(); chk(col, (i == 7), "R4", $sformatf("count restart tick %0d", i));
    end
    quiet();
  endtask

  task automatic t_immediate();
    full_dup = 0; spd_100 = 0; hb_en = 0;
    rx_act = 1; step();
    tx_act = 1; step(); chk(col, 1'b1, "R3", "collision during receive");
    quiet();
    tx_act = 1; rx_act = 1; step(); chk(col, 1'b1, "R3", "simultaneous start");
    quiet();
  endtask

  task automatic t_hold();
    full_dup = 0; spd_100 = 0; hb_en = 0;
    rx_act = 1; tx_act = 1; step();
    rx_act = 0; tx_act = 0;
    repeat (5) @(negedge clk);
    chk(col, 1'b1, "R10", "col held without tick");
    chk(crs, 1'b1, "R10", "crs held without tick");
    step(); chk(crs, 1'b0, "R10", "crs updates on tick");
    quiet();
  endtask

  task automatic t_sqe();
    full_dup = 0; spd_100 = 0; hb_en = 1;
    tx_act = 1; step();
    tx_act = 0; step(); chk(col, 1'b0, "R5", "tick F");
    for (int i = 1; i <= 21; i++) begin
      step(); chk(col, (i >= 10 && i <= 19), "R5", $sformatf("sqe tick F+%0d", i));
    end
    full_dup = 1;
    tx_act = 1; step(); tx_act = 0; step();
    repeat (10) step(); chk(col, 1'b1, "R1", "fd sqe pulse");
    repeat (10) step();
    full_dup = 0; hb_en = 0;
    tx_act = 1; step(); tx_act = 0; step();
    repeat (10) step(); chk(col, 1'b0, "R5", "no pulse heartbeat off");
    hb_en = 1; spd_100 = 1;
    tx_act = 1; step(); tx_act = 0; step();
    repeat (10) step(); chk(col, 1'b0, "R5", "no pulse at 100");
    spd_100 = 0; quiet();
  endtask

  task automatic t_sqe_cancel();
    full_dup = 0; spd_100 = 0; hb_en = 1;
    tx_act = 1; step(); tx_act = 0; step();
    repeat (12) step(); chk(col, 1'b1, "R6", "pulse running");
    tx_act = 1; step(); chk(col, 1'b0, "R6", "pulse cancelled");
    repeat (5) begin
      step(); chk(col, 1'b0, "R6", "stays cancelled");
    end
    tx_act = 0; step();
    repeat (5) step();
    tx_act = 1; step();
    repeat (10) begin
      step(); chk(col, 1'b0, "R6", "cancel in gap");
    end
    hb_en = 0; quiet();
  endtask

  task automatic t_carrier100();
    full_dup = 0; spd_100 = 1; hb_en = 0; sig_det = 1;
    rx_act = 1; rx_bit = 1; step(); step();
    chk(crs, 1'b0, "R8", "rx_act does not start carrier");
    rx_act = 0;
    rx_bit = 0; step(); rx_bit = 0; step();
    chk(crs, 1'b0, "R8", "adjacent zeros");
    rx_bit = 1; step(); chk(crs, 1'b0, "R8", "gap one");
    rx_bit = 0; step(); chk(crs, 1'b1, "R8", "second zero starts carrier");
    tx_act = 1; step(); chk(col, 1'b1, "R3", "100 collision immediate");
    tx_act = 0; rx_act = 1; step(); chk(crs, 1'b1, "R9", "carrier during packet");
    rx_act = 0; step(); chk(crs, 1'b0, "R9", "carrier ends with packet");
    rx_bit = 0; step(); rx_bit = 1; step(); rx_bit = 0; step();
    chk(crs, 1'b1, "R8", "carrier again");
    sig_det = 0; step(); chk(crs, 1'b0, "R9", "signal loss ends carrier");
    spd_100 = 0; rx_act = 1; step(); chk(crs, 1'b1, "R9", "10M rx_act is activity");
    quiet();
  endtask

  initial begin
    n_chk = 0; n_err = 0; done = 0;
    rst_n = 0; bit_tick = 0;
    full_dup = 0; spd_100 = 0; hb_en = 0;
    tx_act = 0; rx_act = 0; sig_det = 0; rx_bit = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_crs_modes();
    t_fd_col();
    t_filter();
    t_immediate();
    t_hold();
    t_sqe();
    t_sqe_cancel();
    t_carrier100();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL R10 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule